// File: doc/BRIEF.md
# Character Display RAM Access Unit

This block is the host side of the RAM path in a character-display controller. A host runs single-cycle bus transfers, marked by a register-select bit and a read/write bit on an 8-bit data bus. The unit keeps a 7-bit address counter that points into one of two memories. The first is a 128-byte display RAM. The second is a 64-byte glyph RAM. The unit also keeps a busy timer and a prefetched read register.

Address-load, cursor-move and step-direction commands come in as single-cycle strobes that are decoded elsewhere. A status transfer returns the busy bit together with the counter. Data writes store a byte and then step the counter. Data reads return the prefetched byte, step the counter and then prefetch again.

The prefetch register is refreshed only in three cases: by an address load, by a cursor move in display RAM, and by a data read. A read that follows writes therefore returns the byte that was captured earlier, not the byte at the current counter.

Top module: `lcd_ram_port`

## Requirements
- R1: A transfer with `bus_rs`=0 and `bus_rw`=1 is always accepted, even while busy. One cycle later it raises `rdata_vld` and returns busy on bit 7 and the counter on bits 6..0, both as they stood before the transfer.
- R2: An accepted command strobe or data write raises `busy` for exactly `BUSY_CYC` cycles, starting the cycle after acceptance. Data reads and status reads never raise `busy`.
- R3: While `busy` is high, the unit ignores command strobes, data writes and data reads. The RAM, the counter, the prefetch register and the step direction are all left unchanged, and a data read produces no `rdata_vld`.
- R4: A data write (`bus_rs`=1, `bus_rw`=0) stores `bus_wdata` into the memory chosen by the last address load. Display RAM uses all 7 counter bits. Glyph RAM uses counter bits 5..0.
- R5: Every accepted data write or data read steps the counter by one. The step is up when the direction bit is 1 and down when it is 0. The counter wraps modulo 128 in display RAM and modulo 64 in glyph RAM, and bit 6 stays 0 in glyph RAM. `cmd_entry` loads the direction from `cmd_entry_inc`.
- R6: `cmd_addr_set` loads the counter from `cmd_addr` and selects glyph RAM when `cmd_addr_cg`=1, keeping only bits 5..0 in that case. It also loads the prefetch register from the new address.
- R7: A data read (`bus_rs`=1, `bus_rw`=1) returns the prefetch register one cycle later with `rdata_vld`. The prefetch register then reloads from the stepped address, so back-to-back reads stream through memory.
- R8: After data writes, a data read returns the byte prefetched before those writes, not the byte at the advanced counter.
- R9: `cmd_shift` moves the counter by one within the selected RAM. It moves up when `cmd_shift_right`=1 and down otherwise. In display RAM it also reloads the prefetch register. In glyph RAM the prefetch register is unchanged.
- R10: After reset the counter is 0, display RAM is selected, the direction is up, `busy` is low, both memories hold 0x00, and the prefetch register reads 0x00 until it is first loaded.
- R11: At most one operation is taken per cycle, in the priority `cmd_addr_set`, then `cmd_shift`, then `cmd_entry`, then the bus transfer. If any strobe is high in a cycle, the bus transfer of that cycle is dropped. A bus transfer with `bus_rs`=0 and `bus_rw`=0 has no effect here.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus transfer strobe, one cycle |
| bus_rs | input | 1 | Register select: 0 status/instruction, 1 data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with `rdata_vld` |
| rdata_vld | output | 1 | Read result present |
| busy | output | 1 | Internal operation in progress |
| cmd_addr_set | input | 1 | Address-load strobe |
| cmd_addr_cg | input | 1 | Address load targets glyph RAM |
| cmd_addr | input | 7 | Address to load |
| cmd_shift | input | 1 | Cursor-move strobe |
| cmd_shift_right | input | 1 | Cursor move direction, 1 up |
| cmd_entry | input | 1 | Step-direction strobe |
| cmd_entry_inc | input | 1 | New direction, 1 up |

## Verification
Directed sequences cover the following cases:
- Writes followed by a read without an address load. This separates a stale prefetch from a live memory fetch.
- Streams of reads after an address load, in both directions. These show whether the prefetch reloads from the stepped address.
- Writes at addresses 0x7F and 0x3F, in each memory. These expose wrap errors and the wrong memory width.
- Cursor moves in each memory. These show whether the refresh is limited to display RAM.
- Strobes colliding with a bus transfer, and operations issued while busy. These test the priority and the ignore rule.

A long run of seeded random mixes then issues operations without waiting for `busy` to clear. A reference model follows along, so every read and every busy sample compares the blocking and prefetch timing against that model.

// File: rtl/lcd_ram_port.sv
`timescale 1ns/1ps
module lcd_ram_port #(
  parameter int AW       = 7,
  parameter int CGW      = 6,
  parameter int BUSY_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_rs,
  input  logic          bus_rw,
  input  logic [AW:0]   bus_wdata,
  output logic [AW:0]   bus_rdata,
  output logic          rdata_vld,
  output logic          busy,
  input  logic          cmd_addr_set,
  input  logic          cmd_addr_cg,
  input  logic [AW-1:0] cmd_addr,
  input  logic          cmd_shift,
  input  logic          cmd_shift_right,
  input  logic          cmd_entry,
  input  logic          cmd_entry_inc
);
  localparam int DW   = AW + 1;
  localparam int DD_N = 1 << AW;
  localparam int CG_N = 1 << CGW;
  localparam int BCW  = $clog2(BUSY_CYC + 1);
  localparam logic [AW-1:0] CG_MASK = AW'((1 << CGW) - 1);

  logic [AW-1:0]  ac;
  logic           sel_cg, inc;
  logic [DW-1:0]  odr;
  logic [BCW-1:0] bcnt;
  logic [DW-1:0]  dd_mem [DD_N];
  logic [DW-1:0]  cg_mem [CG_N];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input logic up, input logic cg);
    logic [AW-1:0] n;
    n = up ? a + 1'b1 : a - 1'b1;
    return cg ? (n & CG_MASK) : n;
  endfunction

  function automatic logic [DW-1:0] fetch(input logic cg, input logic [AW-1:0] a);
    return cg ? cg_mem[a[CGW-1:0]] : dd_mem[a];
  endfunction

  assign busy = (bcnt != '0);

  wire any_cmd  = cmd_addr_set | cmd_shift | cmd_entry;
  wire do_set   = cmd_addr_set & ~busy;
  wire do_shift = cmd_shift & ~cmd_addr_set & ~busy;
  wire do_entry = cmd_entry & ~cmd_addr_set & ~cmd_shift & ~busy;
  wire bus_ok   = bus_en & ~any_cmd;
  wire do_stat  = bus_ok & ~bus_rs & bus_rw;
  wire do_wr    = bus_ok & ~busy & bus_rs & ~bus_rw;
  wire do_rd    = bus_ok & ~busy & bus_rs & bus_rw;

  wire [AW-1:0] set_ac   = cmd_addr_cg ? (cmd_addr & CG_MASK) : cmd_addr;
  wire [AW-1:0] step_ac  = nxt(ac, inc, sel_cg);
  wire [AW-1:0] shift_ac = nxt(ac, cmd_shift_right, sel_cg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac        <= '0;
      sel_cg    <= 1'b0;
      inc       <= 1'b1;
      odr       <= '0;
      bcnt      <= '0;
      bus_rdata <= '0;
      rdata_vld <= 1'b0;
    end else begin
      rdata_vld <= do_stat | do_rd;
      if (do_stat) bus_rdata <= {busy, ac};
      if (do_rd)   bus_rdata <= odr;

      if (do_set | do_shift | do_entry | do_wr) bcnt <= BCW'(BUSY_CYC);
      else if (busy)                            bcnt <= bcnt - BCW'(1);

      if (do_set) begin
        ac     <= set_ac;
        sel_cg <= cmd_addr_cg;
        odr    <= fetch(cmd_addr_cg, set_ac);
      end
      if (do_shift) begin
        ac <= shift_ac;
        if (!sel_cg) odr <= dd_mem[shift_ac];
      end
      if (do_entry) inc <= cmd_entry_inc;
      if (do_wr) ac <= step_ac;
      if (do_rd) begin
        ac  <= step_ac;
        odr <= fetch(sel_cg, step_ac);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DD_N; i++) dd_mem[i] <= '0;
      for (int i = 0; i < CG_N; i++) cg_mem[i] <= '0;
    end else if (do_wr) begin
      if (sel_cg) cg_mem[ac[CGW-1:0]] <= bus_wdata;
      else        dd_mem[ac]          <= bus_wdata;
    end
  end
endmodule

// File: rtl/lcd_ram_port_chk.sv
`timescale 1ns/1ps
module lcd_ram_port_chk #(
  parameter int AW  = 7,
  parameter int CGW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_rs,
  input logic          bus_rw,
  input logic [AW:0]   bus_rdata,
  input logic          rdata_vld,
  input logic          busy,
  input logic          cmd_addr_set,
  input logic          cmd_addr_cg,
  input logic [AW-1:0] cmd_addr,
  input logic          cmd_shift,
  input logic          cmd_entry,
  input logic [AW-1:0] ac,
  input logic          sel_cg,
  input logic          inc,
  input logic [AW:0]   odr
);
  localparam logic [AW-1:0] CG_MASK = AW'((1 << CGW) - 1);
  wire no_cmd = !cmd_addr_set && !cmd_shift && !cmd_entry;

  // R1
  stat_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_rs && bus_rw && no_cmd) |=> rdata_vld && bus_rdata == {$past(busy), $past(ac)});
  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_rs && !bus_rw && !busy && no_cmd) |=> busy);
  // R3
  hold_ac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ac));
  // R3
  hold_odr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(odr));
  // R3
  no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_rs && bus_rw && busy) |=> !rdata_vld);
  // R5
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_rs && !bus_rw && !busy && no_cmd && inc && !sel_cg) |=> ac == $past(ac) + 1'b1);
  // R6
  set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_addr_set && !busy) |=> sel_cg == $past(cmd_addr_cg) &&
      ac == ($past(cmd_addr_cg) ? ($past(cmd_addr) & CG_MASK) : $past(cmd_addr)));
endmodule

bind lcd_ram_port lcd_ram_port_chk #(.AW(AW), .CGW(CGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rs(bus_rs), .bus_rw(bus_rw),
  .bus_rdata(bus_rdata), .rdata_vld(rdata_vld), .busy(busy),
  .cmd_addr_set(cmd_addr_set), .cmd_addr_cg(cmd_addr_cg), .cmd_addr(cmd_addr),
  .cmd_shift(cmd_shift), .cmd_entry(cmd_entry),
  .ac(ac), .sel_cg(sel_cg), .inc(inc), .odr(odr)
);

// File: tb/sim_lcd_ram_port.sv
`timescale 1ns/1ps
module sim_lcd_ram_port;
  localparam int BUSY = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 0, bus_rs = 0, bus_rw = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic rdata_vld, busy;
  logic cmd_addr_set = 0, cmd_addr_cg = 0, cmd_shift = 0, cmd_shift_right = 0;
  logic cmd_entry = 0, cmd_entry_inc = 0;
  logic [6:0] cmd_addr = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string tag = "R10";

  logic [7:0] m_dd [128];
  logic [7:0] m_cg [64];
  logic [6:0] m_ac;
  logic m_cgs, m_inc;
  logic [7:0] m_odr;
  int m_bcnt;

  always #2.5 clk = ~clk;

  lcd_ram_port #(.BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rs(bus_rs), .bus_rw(bus_rw),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rdata_vld(rdata_vld), .busy(busy),
    .cmd_addr_set(cmd_addr_set), .cmd_addr_cg(cmd_addr_cg), .cmd_addr(cmd_addr),
    .cmd_shift(cmd_shift), .cmd_shift_right(cmd_shift_right),
    .cmd_entry(cmd_entry), .cmd_entry_inc(cmd_entry_inc));

  function automatic logic [6:0] mstep(input logic [6:0] a, input logic up, input logic cg);
    logic [6:0] n = up ? a + 7'd1 : a - 7'd1;
    return cg ? {1'b0, n[5:0]} : n;
  endfunction

  function automatic logic [7:0] mrd(input logic cg, input logic [6:0] a);
    return cg ? m_cg[a[5:0]] : m_dd[a];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    foreach (m_dd[i]) m_dd[i] = '0;
    foreach (m_cg[i]) m_cg[i] = '0;
    m_ac = '0; m_cgs = 0; m_inc = 1; m_odr = '0; m_bcnt = 0;
  endtask

  task automatic cyc();
    logic free, bpre, ev, start, bo;
    logic [7:0] er;
    @(posedge clk);
    free = (m_bcnt == 0); bpre = !free; ev = 0; er = '0; start = 0;
    bo = bus_en && !cmd_addr_set && !cmd_shift && !cmd_entry;
    if (cmd_addr_set && free) begin
      m_cgs = cmd_addr_cg;
      m_ac = cmd_addr_cg ? {1'b0, cmd_addr[5:0]} : cmd_addr;
      m_odr = mrd(m_cgs, m_ac); start = 1;
    end else if (cmd_shift && free) begin
      m_ac = mstep(m_ac, cmd_shift_right, m_cgs);
      if (!m_cgs) m_odr = m_dd[m_ac];
      start = 1;
    end else if (cmd_entry && free) begin
      m_inc = cmd_entry_inc; start = 1;
    end else if (bo && !bus_rs && bus_rw) begin
      ev = 1; er = {bpre, m_ac};
    end else if (bo && free && bus_rs && !bus_rw) begin
      if (m_cgs) m_cg[m_ac[5:0]] = bus_wdata; else m_dd[m_ac] = bus_wdata;
      m_ac = mstep(m_ac, m_inc, m_cgs); start = 1;
    end else if (bo && free && bus_rs && bus_rw) begin
      ev = 1; er = m_odr;
      m_ac = mstep(m_ac, m_inc, m_cgs);
      m_odr = mrd(m_cgs, m_ac);
    end
    if (start) m_bcnt = BUSY; else if (m_bcnt > 0) m_bcnt--;
    @(negedge clk);
    check("R2 busy", {7'd0, busy}, {7'd0, m_bcnt != 0});
    check({tag, " rdata_vld"}, {7'd0, rdata_vld}, {7'd0, ev});
    if (ev) check(tag, bus_rdata, er);
  endtask

  task automatic clr();
    bus_en = 0; cmd_addr_set = 0; cmd_shift = 0; cmd_entry = 0;
  endtask

  task automatic idle();
    while (m_bcnt != 0) cyc();
  endtask

  task automatic op_stat(); clr(); bus_en = 1; bus_rs = 0; bus_rw = 1; cyc(); clr(); endtask
  task automatic op_wr(input logic [7:0] d); clr(); bus_en = 1; bus_rs = 1; bus_rw = 0; bus_wdata = d; cyc(); clr(); endtask
  task automatic op_rd(); clr(); bus_en = 1; bus_rs = 1; bus_rw = 1; cyc(); clr(); endtask
  task automatic op_set(input logic cg, input logic [6:0] a); clr(); cmd_addr_set = 1; cmd_addr_cg = cg; cmd_addr = a; cyc(); clr(); endtask
  task automatic op_shift(input logic r); clr(); cmd_shift = 1; cmd_shift_right = r; cyc(); clr(); endtask
  task automatic op_entry(input logic up); clr(); cmd_entry = 1; cmd_entry_inc = up; cyc(); clr(); endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R10"; op_stat(); op_rd(); idle();
    // R8: writes then read without reload returns the earlier prefetch
    tag = "R4"; op_set(0, 7'h10); idle();
    op_wr(8'hA1); idle(); op_wr(8'hA2); idle(); op_wr(8'hA3); idle();
    tag = "R8"; op_rd(); idle();
    tag = "R7"; op_set(0, 7'h10); idle(); op_rd(); op_rd(); op_rd();
    tag = "R5"; op_entry(0); idle(); op_set(0, 7'h12); idle(); op_rd(); op_rd(); op_stat();
    op_entry(1); idle();
    op_set(1, 7'h7F); idle(); op_stat(); op_wr(8'h55); idle(); op_stat();
    op_set(0, 7'h7F); idle(); op_wr(8'h66); idle(); op_stat();
    tag = "R6"; op_set(1, 7'h3F); idle(); op_rd(); op_rd();
    tag = "R9"; op_set(0, 7'h0F); idle(); op_shift(1); idle(); op_rd();
    op_set(1, 7'h00); idle(); op_shift(0); idle(); op_stat(); op_rd();
    tag = "R3"; op_set(0, 7'h20); op_wr(8'hEE); op_rd(); op_stat(); op_entry(0); idle();
    op_set(0, 7'h20); idle(); op_rd();
    tag = "R11"; clr(); cmd_addr_set = 1; cmd_addr = 7'h30; bus_en = 1; bus_rs = 0; bus_rw = 1; cyc(); clr(); idle();
    clr(); cmd_shift = 1; cmd_entry = 1; cmd_entry_inc = 0; cmd_shift_right = 1; cyc(); clr(); idle(); op_stat();
    op_rd(); op_rd(); op_stat();
    op_entry(1); idle();
    tag = "R1"; op_wr(8'h11); op_stat(); op_stat(); idle(); op_stat();
    void'($urandom(32'd20240611));
    tag = "R7 random";
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom_range(0, 8);
      case (k)
        0: op_stat();
        1, 2: op_wr(8'($urandom));
        3, 4: op_rd();
        5: op_set(1'($urandom), 7'($urandom));
        6: op_shift(1'($urandom));
        7: op_entry(1'($urandom));
        default: if ($urandom_range(0, 1) == 1) idle(); else cyc();
      endcase
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule